// File: doc/BRIEF.md
# Grouped Interrupt Status Aggregator

This block folds a wide vector of per-pin pending flags into a compact set of summary bits, one bit for every four consecutive pins, and raises one shared interrupt line toward the host. Software reads the summary bits through two 32-bit words to find which group of pins needs service. It then ends the service round by pulsing an end-of-interrupt strobe.

A second function guards against status produced by reconfiguration. When the blocking feature is enabled, any write to a pin's debounce settings starts a global quiet window whose length is programmed in core clock cycles. While that window is open, the summary bits are frozen and the per-pin interrupt-enable read-back is forced to zero for every pin. Software can therefore poll one enable bit until it reads as set again, and so learn that the window has closed.

Top module: `irq_group_agg`

## Requirements
- R1: Summary bit g is registered and, one clock edge after the inputs are sampled, equals the OR of pending pins 4g, 4g+1, 4g+2 and 4g+3.
- R2: There are 46 summary bits. Bits 0 to 31 appear on `sum_lo[31:0]`, and bits 32 to 45 appear on `sum_hi[13:0]`.
- R3: `sum_hi[31:14]` always reads as zero, including when every pin is pending.
- R4: `host_irq` goes high on the clock edge at which any summary bit changes from 0 to 1. It then stays high until an end-of-interrupt.
- R5: An `eoi_wr` pulse with no summary bit rising at the same edge drives `host_irq` low at that edge. The line stays low while the summary bits only hold or fall. A summary bit that rises on the same edge as the end-of-interrupt keeps the line high.
- R6: With `blk_en`=1 and `blk_len`=L (L not 0), a `dbnc_wr` pulse leaves the summary bits frozen for the L clock edges after the write edge. Another write during the window restarts the count from the new length.
- R7: While the blocking window is open, `int_en_rd` is all zeros. At all other times it equals `int_en_cfg`.
- R8: A `dbnc_wr` pulse has no effect on the summary bits or on `int_en_rd` when `blk_en`=0 or `blk_len`=0.
- R9: During reset the summary bits are zero, `host_irq` is low and no blocking window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_pend | input | 184 | Per-pin pending flags |
| int_en_cfg | input | 184 | Per-pin interrupt-enable configuration bits |
| dbnc_wr | input | 1 | One-cycle strobe: a debounce setting was written |
| eoi_wr | input | 1 | One-cycle end-of-interrupt strobe |
| blk_en | input | 1 | Enables the blocking window after debounce writes |
| blk_len | input | 12 | Blocking window length in clock cycles |
| int_en_rd | output | 184 | Interrupt-enable read-back, gated by the window |
| sum_lo | output | 32 | Summary bits 0 to 31 |
| sum_hi | output | 32 | Summary bits 32 to 45 in the low 14 bits, zero above |
| host_irq | output | 1 | Shared interrupt line to the host |

## Verification
The bench builds the block with its default parameters: 184 pins, groups of four and a 12-bit length. With these values the last group (pins 180 to 183) lands in `sum_hi[13]`, and the fixed zero region of the upper word can be observed directly. Short window lengths of 3 and 5 cycles let every cycle of a window be compared against the model, and make a restart in mid-window reachable. A walk through all 46 groups, together with end-of-interrupt pulses that coincide with new status, covers the line's arming rules.

// File: rtl/irq_group_agg.sv
module irq_group_agg #(
  parameter int NUM_PINS = 184,
  parameter int GRP      = 4,
  parameter int LEN_W    = 12,
  parameter int WORD     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_pend,
  input  logic [NUM_PINS-1:0] int_en_cfg,
  input  logic                dbnc_wr,
  input  logic                eoi_wr,
  input  logic                blk_en,
  input  logic [LEN_W-1:0]    blk_len,
  output logic [NUM_PINS-1:0] int_en_rd,
  output logic [WORD-1:0]     sum_lo,
  output logic [WORD-1:0]     sum_hi,
  output logic                host_irq
);
  localparam int NUM_SUM = NUM_PINS / GRP;
  localparam int HI_PAD  = 2 * WORD - NUM_SUM;

  logic [NUM_SUM-1:0] grp_or, sum_q, sum_d;
  logic [LEN_W-1:0]   blk_cnt;
  logic               irq_q;

  genvar g;
  generate
    for (g = 0; g < NUM_SUM; g++) begin : g_or
      assign grp_or[g] = |pin_pend[g*GRP +: GRP];
    end
  endgenerate

  wire blocked   = |blk_cnt;
  wire blk_start = dbnc_wr & blk_en & (|blk_len);
  assign sum_d   = blocked ? sum_q : grp_or;
  wire new_stat  = |(sum_d & ~sum_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      blk_cnt <= '0;
      irq_q   <= 1'b0;
    end else begin
      sum_q <= sum_d;
      if (blk_start)    blk_cnt <= blk_len;
      else if (blocked) blk_cnt <= blk_cnt - LEN_W'(1);
      if (new_stat)     irq_q <= 1'b1;
      else if (eoi_wr)  irq_q <= 1'b0;
    end
  end

  assign sum_lo    = sum_q[WORD-1:0];
  assign sum_hi    = {{HI_PAD{1'b0}}, sum_q[NUM_SUM-1:WORD]};
  assign int_en_rd = blocked ? '0 : int_en_cfg;
  assign host_irq  = irq_q;

  // R1
  group0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_cnt == '0) |=> (sum_lo[0] == $past(|pin_pend[GRP-1:0])));

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> ((sum_lo | sum_hi) != '0));

  // R5
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> $past(eoi_wr));

  // R6
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_cnt != '0) |=> ($stable(sum_lo) && $stable(sum_hi)));

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbnc_wr && blk_en && (blk_len != '0)) |-> (int_en_rd == '0));

  // R8
  no_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbnc_wr && (!blk_en || blk_len == '0) && blk_cnt == '0) |=> (int_en_rd == int_en_cfg));
endmodule

// File: tb/irq_group_agg_bench.sv
module irq_group_agg_bench;
  localparam int NP = 184;
  localparam int NS = 46;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pin_pend = '0, int_en_cfg = '0;
  logic dbnc_wr = 1'b0, eoi_wr = 1'b0, blk_en = 1'b0;
  logic [11:0] blk_len = '0;
  logic [NP-1:0] int_en_rd;
  logic [31:0] sum_lo, sum_hi;
  logic host_irq;

  always #4 clk = ~clk;

  irq_group_agg u_irq_group_agg (
    .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .int_en_cfg(int_en_cfg),
    .dbnc_wr(dbnc_wr), .eoi_wr(eoi_wr), .blk_en(blk_en), .blk_len(blk_len),
    .int_en_rd(int_en_rd), .sum_lo(sum_lo), .sum_hi(sum_hi), .host_irq(host_irq));

  typedef struct packed {
    logic [31:0]   lo;
    logic [31:0]   hi;
    logic          irq;
    logic [NP-1:0] en;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [NS-1:0] m_sum = '0;
  int            m_cnt = 0;
  logic          m_irq = 1'b0;
  localparam logic [NP-1:0] EN_PAT = {46{4'b0110}};

  function automatic logic [NP-1:0] pin(int p);
    return {{(NP-1){1'b0}}, 1'b1} << p;
  endfunction

  task automatic step(string tag, logic [NP-1:0] pend, logic dw, logic eo,
                      logic be, logic [11:0] len);
    logic [NS-1:0] nsum;
    logic nirq;
    int ncnt;
    exp_t e;
    @(negedge clk);
    pin_pend = pend; dbnc_wr = dw; eoi_wr = eo; blk_en = be; blk_len = len;
    int_en_cfg = EN_PAT;
    for (int g = 0; g < NS; g++) nsum[g] = (m_cnt != 0) ? m_sum[g] : |pend[g*4 +: 4];
    if ((nsum & ~m_sum) != '0) nirq = 1'b1;
    else if (eo)               nirq = 1'b0;
    else                       nirq = m_irq;
    if (dw && be && len != 0) ncnt = int'(len);
    else if (m_cnt != 0)      ncnt = m_cnt - 1;
    else                      ncnt = 0;
    m_sum = nsum; m_irq = nirq; m_cnt = ncnt;
    e.lo  = nsum[31:0];
    e.hi  = {18'b0, nsum[45:32]};
    e.irq = nirq;
    e.en  = (ncnt != 0) ? '0 : EN_PAT;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (sum_lo !== e.lo || sum_hi !== e.hi || host_irq !== e.irq || int_en_rd !== e.en) begin
          fails++;
          $display("FAIL %s got lo=%h hi=%h irq=%b en=%h exp lo=%h hi=%h irq=%b en=%h",
                   t, sum_lo, sum_hi, host_irq, int_en_rd, e.lo, e.hi, e.irq, e.en);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (sum_lo !== '0 || sum_hi !== '0 || host_irq !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset got lo=%h hi=%h irq=%b exp lo=0 hi=0 irq=0", sum_lo, sum_hi, host_irq);
    end
    rst_n = 1'b1;

    step("R1 pin0",            pin(0),   0, 0, 1, 12'd5);
    step("R1 pin3 same group", pin(3),   0, 0, 1, 12'd5);
    step("R5 eoi drops line",  pin(3),   0, 1, 1, 12'd5);
    step("R5 stays low",       pin(3),   0, 0, 1, 12'd5);
    step("R2 pin127 lo bit31", pin(127), 0, 0, 1, 12'd5);
    step("R5 eoi with rise",   pin(128), 0, 1, 1, 12'd5);
    step("R2 pin183 hi bit13", pin(183), 0, 0, 1, 12'd5);
    step("R3 all pending",     '1,       0, 0, 1, 12'd5);
    step("R5 eoi all pending", '1,       0, 1, 1, 12'd5);
    step("R5 hold all pend",   '1,       0, 0, 1, 12'd5);
    step("R4 clear",           '0,       0, 0, 1, 12'd5);

    for (int g = 0; g < NS; g++) begin
      step("R1 R2 group walk", pin(4*g + (g % 4)), 0, (g % 3) == 0, 1, 12'd5);
    end
    step("R4 idle", '0, 0, 1, 1, 12'd5);

    step("R6 start window", '0, 1, 0, 1, 12'd5);
    for (int i = 0; i < 7; i++) step("R6 R7 frozen", pin(20), 0, 0, 1, 12'd5);

    step("R6 start len3", '0, 1, 1, 1, 12'd3);
    step("R6 mid",         pin(40), 0, 0, 1, 12'd3);
    step("R6 reload",      pin(40), 1, 0, 1, 12'd3);
    for (int i = 0; i < 5; i++) step("R6 R7 after reload", pin(60), 0, 0, 1, 12'd3);

    step("R8 blk_en off", pin(1), 1, 1, 0, 12'd5);
    step("R8 no freeze",  pin(90), 0, 0, 0, 12'd5);
    step("R8 len zero",   pin(2), 1, 0, 1, 12'd0);
    step("R8 no freeze2", pin(150), 0, 0, 1, 12'd0);
    step("R7 idle",       '0, 0, 1, 1, 12'd0);

    @(negedge clk);
    dbnc_wr = 0; eoi_wr = 0;
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule